// File: doc/BRIEF.md
# Word-Parallel Pseudo-Random Link Tester

This block exercises a serial link one parallel word at a time. Its transmit half produces a chosen test sequence and places one word per clock on a transceiver-style data bus. Its receive half takes the words that come back and regenerates the same sequence locally to compare against them. It aligns itself to the incoming stream without any handshake: it takes its starting state from the received data, then runs freely once it has seen enough clean words.

The sequence menu holds four maximal-length shift-register sequences and two square-wave sequences. Run-time controls select the sequence, invert either direction, slip one deliberate bit error into the transmit stream, and zero the statistics. The statistics are a bit-error total and a received-word total, both of which stop at full scale. A lock flag shows whether the receiver is aligned. In the bench the loop is closed by wiring the transmit bus to the receive bus through an error-injecting channel.

Top module: `prbs_bert`

## Requirements
- R1: `seq_sel` codes 0, 1, 2 and 3 give shift-register sequences of length L = 7, 15, 23 and 31, whose taps are T = 6, 14, 18 and 28. Codes 6 and 7 behave as code 0. Bits leave MSB first, and every bit equals the XOR of the bits L and T positions earlier in the continuous stream.
- R2: Code 4 gives a bit-rate square wave. Every word is alternating ones and zeros with a 1 in the MSB (32'hAAAAAAAA for W=32).
- R3: Code 5 gives five ones followed by five zeros, repeated, continuous across word boundaries. Each stream bit equals the bit 10 earlier and differs from the bit 5 earlier.
- R4: With `tx_flip` high, every bit of `tx_word` is the inverse of the sequence value.
- R5: `inject` high in a cycle flips bit 0 of the word registered on that edge and of no other word. The sequence continues as if nothing had been flipped.
- R6: `in_sync` is 0 after reset. It rises after SYNC_RUN consecutive received words with no mismatch, and never sooner.
- R7: While `in_sync` is 1, LOSS_RUN consecutive mismatching words clear it. A run of LOSS_RUN-1 such words does not.
- R8: While `in_sync` is 1, `bit_errs` grows by the number of mismatching bits in each received word. While it is 0, `bit_errs` does not change.
- R9: `word_total` grows by one on every clock edge.
- R10: `stat_clr` high at an edge sets both counters to 0 on that edge, overriding any increment.
- R11: Both counters hold at 2^CNT_W-1 instead of wrapping.
- R12: `rx_flip` inverts every received bit before comparison. With both flips set, the loop syncs with zero errors. With only one set, the receiver cannot sync to a shift-register sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_sel | input | 3 | Sequence code (R1–R3) |
| tx_flip | input | 1 | Invert transmit data |
| rx_flip | input | 1 | Invert receive data |
| inject | input | 1 | Flip one bit of the next transmit word |
| stat_clr | input | 1 | Clear both counters |
| tx_word | output | W | Transmit data word, registered |
| rx_word | input | W | Receive data word |
| in_sync | output | 1 | Receiver aligned |
| bit_errs | output | CNT_W | Saturating bit-error total |
| word_total | output | CNT_W | Saturating received-word total |

## Verification
The assertions assume that the sequence code changes only between runs and that `stat_clr` is a clean synchronous level. They also assume that a locked receiver sees no more than W bit errors per word, which holds because a word has only W bits. The stimulus holds the sequence code steady for dozens of cycles after each change, so the receiver can drop and regain sync. Random channel errors and injections are separated by at least one clean word, so they never form a run long enough to break sync. Loss of sync is produced only by the directed runs of bad words.

// File: rtl/prbs_bert.sv
module prbs_bert #(
  parameter int W = 32,
  parameter int CNT_W = 32,
  parameter int SYNC_RUN = 8,
  parameter int LOSS_RUN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       seq_sel,
  input  logic             tx_flip,
  input  logic             rx_flip,
  input  logic             inject,
  input  logic             stat_clr,
  output logic [W-1:0]     tx_word,
  input  logic [W-1:0]     rx_word,
  output logic             in_sync,
  output logic [CNT_W-1:0] bit_errs,
  output logic [CNT_W-1:0] word_total
);
  localparam int NB = $clog2(W + 1);
  localparam int SB = $clog2(SYNC_RUN + 1);
  localparam int LB = $clog2(LOSS_RUN + 1);
  localparam int WSTEP = W % 10;
  localparam logic [CNT_W-1:0] FULL = '1;

  function automatic logic [W-1:0] sq10(input logic [3:0] ph);
    for (int i = 0; i < W; i++)
      sq10[i] = ((32'(ph) + 32'(W - 1 - i)) % 10) < 5;
  endfunction

  function automatic logic [W-1:0] gen_word(input logic [2:0] sel, input logic [30:0] st);
    logic [30:0] s;
    logic nb;
    int l, t;
    gen_word = '0;
    case (sel)
      3'd1: begin l = 15; t = 14; end
      3'd2: begin l = 23; t = 18; end
      3'd3: begin l = 31; t = 28; end
      default: begin l = 7; t = 6; end
    endcase
    if (sel == 3'd4) begin
      for (int i = 0; i < W; i++) gen_word[i] = (i % 2) == 1;
    end else if (sel == 3'd5) begin
      gen_word = sq10(st[3:0]);
    end else begin
      s = st;
      if ((s & 31'((64'd1 << l) - 64'd1)) == 31'd0) s = '1;
      for (int i = W - 1; i >= 0; i--) begin
        nb = s[l-1] ^ s[t-1];
        gen_word[i] = nb;
        s = {s[29:0], nb};
      end
    end
  endfunction

  function automatic logic [30:0] nxt_state(input logic [2:0] sel, input logic [30:0] st,
                                            input logic [W-1:0] w);
    if (sel == 3'd4) nxt_state = st;
    else if (sel == 3'd5) nxt_state = 31'((32'(st[3:0]) + WSTEP) % 10);
    else nxt_state = w[30:0];
  endfunction

  logic [30:0] tx_st, chk_st, seed;
  logic [W-1:0] tx_seq, rx_w, exp_w;
  logic [NB-1:0] nerr;
  logic [SB-1:0] good_run;
  logic [LB-1:0] bad_run;
  logic [CNT_W:0] err_sum;

  assign tx_seq  = gen_word(seq_sel, tx_st);
  assign rx_w    = rx_word ^ {W{rx_flip}};
  assign exp_w   = gen_word(seq_sel, chk_st);
  assign nerr    = NB'($countones(rx_w ^ exp_w));
  assign err_sum = {1'b0, bit_errs} + (CNT_W+1)'(nerr);

  always_comb begin
    seed = '0;
    if (seq_sel == 3'd5) begin
      for (int p = 0; p < 10; p++)
        if (sq10(4'(p)) == rx_w) seed = 31'((p + WSTEP) % 10);
    end else if (seq_sel != 3'd4) begin
      seed = rx_w[30:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st   <= '1;
      tx_word <= '0;
    end else begin
      tx_st   <= nxt_state(seq_sel, tx_st, tx_seq);
      tx_word <= tx_seq ^ {W{tx_flip}} ^ W'(inject);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_sync  <= 1'b0;
      good_run <= '0;
      bad_run  <= '0;
      chk_st   <= '1;
    end else if (!in_sync) begin
      chk_st  <= seed;
      bad_run <= '0;
      if (nerr != 0) good_run <= '0;
      else if (good_run == SB'(SYNC_RUN - 1)) begin
        in_sync  <= 1'b1;
        good_run <= '0;
      end else good_run <= good_run + 1'b1;
    end else begin
      chk_st <= nxt_state(seq_sel, chk_st, exp_w);
      if (nerr == 0) bad_run <= '0;
      else if (bad_run == LB'(LOSS_RUN - 1)) begin
        in_sync <= 1'b0;
        bad_run <= '0;
      end else bad_run <= bad_run + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stat_clr) begin
      bit_errs   <= '0;
      word_total <= '0;
    end else begin
      if (word_total != FULL) word_total <= word_total + 1'b1;
      if (in_sync) bit_errs <= err_sum > {1'b0, FULL} ? FULL : err_sum[CNT_W-1:0];
    end
  end
endmodule

module prbs_bert_chk #(
  parameter int W = 32,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       seq_sel,
  input logic             tx_flip,
  input logic             inject,
  input logic             stat_clr,
  input logic [W-1:0]     tx_word,
  input logic             in_sync,
  input logic [CNT_W-1:0] bit_errs,
  input logic [CNT_W-1:0] word_total
);
  localparam logic [CNT_W-1:0] FULL = '1;
  localparam logic [W-1:0] ALT = {(W/2){2'b10}};

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (bit_errs == '0 && word_total == '0)); // R10
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_clr && word_total != FULL) |=> word_total == $past(word_total) + 1'b1); // R9
  AST_WORD_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_clr && word_total == FULL) |=> word_total == FULL); // R11
  AST_ERR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_clr && bit_errs == FULL) |=> bit_errs == FULL); // R11
  AST_NO_COUNT_UNSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_clr && !in_sync) |=> $stable(bit_errs)); // R8
  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr |=> (bit_errs >= $past(bit_errs) && bit_errs - $past(bit_errs) <= CNT_W'(W))); // R8
  AST_SQUARE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_sel == 3'd4 && !tx_flip && !inject) |=> tx_word == ALT); // R2
  AST_SQUARE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_sel == 3'd4 && tx_flip && !inject) |=> tx_word == ~ALT); // R4
endmodule

bind prbs_bert prbs_bert_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .seq_sel(seq_sel), .tx_flip(tx_flip), .inject(inject),
  .stat_clr(stat_clr), .tx_word(tx_word), .in_sync(in_sync), .bit_errs(bit_errs),
  .word_total(word_total)
);

// File: tb/prbs_bert_bench.sv
`timescale 1ns/1ps
module prbs_bert_bench;
  localparam int W = 32, CW = 8, SR = 8, LR = 4;
  localparam int FULLV = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic [2:0] seq_sel = 0;
  logic tx_flip = 0, rx_flip = 0, inject = 0, stat_clr = 0;
  logic [W-1:0] tx_word, chan = '0;
  logic in_sync;
  logic [CW-1:0] bit_errs, word_total;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  prbs_bert #(.W(W), .CNT_W(CW), .SYNC_RUN(SR), .LOSS_RUN(LR)) u_prbs_bert (
    .clk(clk), .rst_n(rst_n), .seq_sel(seq_sel), .tx_flip(tx_flip), .rx_flip(rx_flip),
    .inject(inject), .stat_clr(stat_clr), .tx_word(tx_word), .rx_word(tx_word ^ chan),
    .in_sync(in_sync), .bit_errs(bit_errs), .word_total(word_total));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear();
    stat_clr = 1; step(1); stat_clr = 0;
  endtask

  function automatic bit bit_at(input logic [2*W-1:0] c, input int j);
    return c[2*W-1-j];
  endfunction

  function automatic bit lfsr_ok(input logic [W-1:0] p, input logic [W-1:0] c, input int l, input int t);
    logic [2*W-1:0] cat = {p, c};
    for (int j = W; j < 2*W; j++)
      if (bit_at(cat, j) != (bit_at(cat, j-l) ^ bit_at(cat, j-t))) return 0;
    return 1;
  endfunction

  function automatic bit sq10_ok(input logic [W-1:0] p, input logic [W-1:0] c);
    logic [2*W-1:0] cat = {p, c};
    for (int j = W; j < 2*W; j++)
      if (bit_at(cat, j) != bit_at(cat, j-10) || bit_at(cat, j) == bit_at(cat, j-5)) return 0;
    return 1;
  endfunction

  function automatic bit seq_ok(input int sel, input logic [W-1:0] p, input logic [W-1:0] c);
    case (sel)
      1: return lfsr_ok(p, c, 15, 14);
      2: return lfsr_ok(p, c, 23, 18);
      3: return lfsr_ok(p, c, 31, 28);
      4: return c == {(W/2){2'b10}};
      5: return sq10_ok(p, c);
      default: return lfsr_ok(p, c, 7, 6);
    endcase
  endfunction

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] pw, cw, nw, m;
    int exp_e;
    void'($urandom(32'd1234));
    step(3);
    check(in_sync == 0, "R6 reset sync", in_sync, 0);
    check(bit_errs == 0 && word_total == 0, "R10 reset counters", word_total, 0);
    rst_n = 1;
    step(SR - 1);
    check(in_sync == 0, "R6 no early sync", in_sync, 0);
    step(4);
    check(in_sync == 1, "R6 sync", in_sync, 1);

    for (int s = 0; s < 8; s++) begin
      seq_sel = 3'(s);
      step(40);
      check(in_sync == 1, "R6 sync per code", s, 1);
      clear();
      check(word_total == 0 && bit_errs == 0, "R10 clear", word_total, 0);
      step(20);
      check(word_total == 20, "R9 word count", word_total, 20);
      check(bit_errs == 0, "R8 clean loop", bit_errs, 0);
      for (int k = 0; k < 3; k++) begin
        pw = tx_word; step(1); cw = tx_word;
        check(seq_ok(s, pw, cw), s == 4 ? "R2 square word" : (s == 5 ? "R3 ten-bit square" : "R1 recurrence"), cw, s);
      end
    end

    seq_sel = 4; tx_flip = 1; rx_flip = 1; step(2);
    check(tx_word == ~{(W/2){2'b10}}, "R4 tx inversion", tx_word, ~{(W/2){2'b10}});
    seq_sel = 1; step(40); clear(); step(30);
    check(in_sync == 1 && bit_errs == 0, "R12 both flipped", bit_errs, 0);
    rx_flip = 0; step(20);
    check(in_sync == 0, "R12 one flip no sync", in_sync, 0);
    clear(); step(10);
    check(bit_errs == 0, "R8 no count unsynced", bit_errs, 0);
    tx_flip = 0; step(40);
    check(in_sync == 1, "R12 resync", in_sync, 1);

    clear(); step(2);
    pw = tx_word; inject = 1; step(1); inject = 0; cw = tx_word; step(1); nw = tx_word;
    check(!lfsr_ok(pw, cw, 15, 14), "R5 bit flipped", cw, pw);
    check(lfsr_ok(pw, cw ^ 1, 15, 14) && lfsr_ok(cw ^ 1, nw, 15, 14), "R5 single bit 0 only", cw, nw);
    step(4);
    check(bit_errs == 1, "R5 one error counted", bit_errs, 1);

    for (int r = 0; r < 4; r++) begin
      seq_sel = 3'($urandom % 6);
      step(40); clear(); exp_e = 0;
      for (int e = 0; e < 20; e++) begin
        step(1 + $urandom % 5);
        if ($urandom % 3 == 0) begin
          inject = 1; step(1); inject = 0; exp_e += 1;
        end else begin
          m = $urandom & $urandom & $urandom;
          chan = m; step(1); chan = '0; exp_e += $countones(m);
        end
      end
      step(4);
      if (exp_e > FULLV) exp_e = FULLV;
      check(in_sync == 1 && bit_errs == CW'(exp_e), "R8 random errors", bit_errs, exp_e);
    end

    seq_sel = 3; step(40); clear();
    chan = 32'h0000_0100; step(LR - 1); chan = '0;
    check(in_sync == 1, "R7 short bad run keeps sync", in_sync, 1);
    check(bit_errs == CW'(LR - 1), "R8 per-word count", bit_errs, LR - 1);
    step(2);
    chan = 32'h0000_0100; step(LR);
    check(in_sync == 0, "R7 loss of sync", in_sync, 0);
    chan = '0; step(40);
    check(in_sync == 1, "R6 resync after loss", in_sync, 1);

    clear(); step(300);
    check(word_total == CW'(FULLV), "R11 word saturation", word_total, FULLV);
    clear();
    for (int e = 0; e < 9; e++) begin
      chan = '1; step(1); chan = '0; step(1);
    end
    check(bit_errs == CW'(FULLV), "R11 error saturation", bit_errs, FULLV);
    chan = '1; step(1); chan = '0; step(2);
    check(bit_errs == CW'(FULLV), "R11 error hold", bit_errs, FULLV);
    clear();
    check(bit_errs == 0 && word_total == 0, "R10 clear after saturation", bit_errs, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule